// File: doc/BRIEF.md
# Three-Stage Accumulator Core with Port-Sharing Stall

This block is a small accumulator processor that runs a fetch, decode and execute pipeline, one cycle per stage, with the three stages overlapping. Each 16-bit instruction carries an opcode, an addressing-mode flag and a 12-bit operand. The operand is used either as a literal value or as the address of a memory word. The instruction set has four operations: load, add, store and halt. Any other opcode passes through the pipeline with no effect.

The core drives two synchronous memory request ports. Port A always carries instruction fetches. Read data comes back one cycle after the request. When `SPLIT_PORTS` is 0, every data access also goes over port A, and port B stays idle. A data access made while an instruction sits in decode therefore takes the port away from the fetch stage for that cycle. The next fetch waits, and a bubble travels down the pipe. When `SPLIT_PORTS` is 1, data accesses use port B, and fetching never pauses.

The accumulator, a halt flag and a count of retired instructions are registered outputs so a bench can observe progress. A halt instruction stops fetching, lets the instructions ahead of it finish, and then freezes the core until reset.

Top module: `acc_pipe_core`

## Requirements
- R1: While reset is high, the accumulator, the halted flag and the retired count all read 0, and port A presents fetch address 0.
- R2: Instruction fields are: opcode in bits 15:13 (000 load, 001 add, 010 store, 111 halt), mode flag in bit 12 (1 = operand is the value), and operand in bits 11:0. An immediate load sets the accumulator to the zero-extended operand. Add wraps modulo 2^16.
- R3: With the mode flag at 0, load and add take their value from the memory word at the operand address.
- R4: A store writes the accumulator to the memory word at its operand address whatever its mode flag. The stored value includes the result of the instruction just before it.
- R5: Instruction n (counting from 0) of a program with no data accesses retires at clock edge n+3 after reset release, one per cycle. A 9-instruction program therefore shows a retired count of 9 after edge 11.
- R6: With shared ports, each direct load, direct add or store delays all later instructions by exactly one cycle.
- R7: With split ports, data accesses go out on port B, and the same program retires one instruction per cycle with no delay.
- R8: After a halt, no instruction that follows it is fetched or executed. The halted flag rises at the edge where the halt retires, and the halt is counted in the retired total. From then on the halted flag stays high, the accumulator and the retired count hold their values, and neither port issues a request.
- R9: An instruction that uses the accumulator written by the instruction just before it gets the new value, with no extra cycle.
- R10: An opcode other than the four defined ones retires without changing the accumulator or memory, and it makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | output | 1 | Port A request (fetch, or data access when shared) |
| a_we | output | 1 | Port A write enable |
| a_addr | output | ADDR_W | Port A word address |
| a_wdata | output | DATA_W | Port A write data |
| a_rdata | input | DATA_W | Port A read data, one cycle after the request |
| b_req | output | 1 | Port B request (split mode only) |
| b_we | output | 1 | Port B write enable |
| b_addr | output | ADDR_W | Port B word address |
| b_wdata | output | DATA_W | Port B write data |
| b_rdata | input | DATA_W | Port B read data, one cycle after the request |
| acc_out | output | DATA_W | Accumulator |
| halted | output | 1 | High once a halt has retired |
| retired | output | CNT_W | Count of retired instructions |

## Verification
A fault in the program counter or in the stall decision shows up at the accumulator on the very next retirement. If a fetch is not held back during a shared-port data cycle, decode reads a data word as if it were an instruction, or the core skips one. If a bubble is missing or extra, the halt edge moves away from its predicted cycle. A store that misses the forwarded result leaves a stale word in memory, and that word is caught when it is read back later in the same program. A halt that leaks shows as a request or as a change in the accumulator or the retired count within a cycle or two after the halted flag rises.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int OP_W  = 3;
  localparam int HDR_W = OP_W + 1;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'b000,
    OP_ADD   = 3'b001,
    OP_STORE = 3'b010,
    OP_HALT  = 3'b111
  } opc_e;
endpackage

// File: rtl/acp_fetch.sv
module acp_fetch #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_busy,
  input  logic              halt_dec,
  output logic [ADDR_W-1:0] pc,
  output logic              fire,
  output logic              dec_valid
);
  logic stopped;

  // a fetch goes out unless the shared port is taken or a halt has been seen
  assign fire = !port_busy && !halt_dec && !stopped;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      dec_valid <= 1'b0;
      stopped   <= 1'b0;
    end else begin
      dec_valid <= fire;
      if (fire)     pc      <= pc + ADDR_W'(1);
      if (halt_dec) stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/acp_decode.sv
module acp_decode #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter bit SHARED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] st_data,
  output logic              dmem_go,
  output logic              dmem_we,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              port_busy,
  output logic              halt_dec,
  output logic              ex_valid,
  output logic              ex_load,
  output logic              ex_add,
  output logic              ex_halt,
  output logic              ex_from_mem,
  output logic [DATA_W-1:0] ex_imm
);
  acp_pkg::opc_e     opc;
  logic              imm_mode;
  logic [ADDR_W-1:0] opnd;
  logic              is_load, is_add, is_store, is_halt;

  always_comb begin
    opc      = acp_pkg::opc_e'(instr[DATA_W-1 -: acp_pkg::OP_W]);
    imm_mode = instr[ADDR_W];
    opnd     = instr[ADDR_W-1:0];
    is_load  = (opc == acp_pkg::OP_LOAD);
    is_add   = (opc == acp_pkg::OP_ADD);
    is_store = (opc == acp_pkg::OP_STORE);
    is_halt  = (opc == acp_pkg::OP_HALT);
  end

  // data access is launched while the instruction sits in decode,
  // so its read word is on the port by the time it executes
  assign dmem_go    = dec_valid && (is_store || ((is_load || is_add) && !imm_mode));
  assign dmem_we    = dec_valid && is_store;
  assign dmem_addr  = opnd;
  assign dmem_wdata = st_data;
  assign port_busy  = SHARED && dmem_go;
  assign halt_dec   = dec_valid && is_halt;

  always_ff @(posedge clk) begin
    if (rst) ex_valid <= 1'b0;
    else     ex_valid <= dec_valid;
    ex_load     <= is_load;
    ex_add      <= is_add;
    ex_halt     <= is_halt;
    ex_from_mem <= (is_load || is_add) && !imm_mode;
    ex_imm      <= {{(DATA_W-ADDR_W){1'b0}}, opnd};
  end
endmodule

// File: rtl/acp_execute.sv
module acp_execute #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_valid,
  input  logic              ex_load,
  input  logic              ex_add,
  input  logic              ex_halt,
  input  logic              ex_from_mem,
  input  logic [DATA_W-1:0] ex_imm,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic              halted,
  output logic [CNT_W-1:0]  retired,
  output logic [DATA_W-1:0] fwd
);
  logic [DATA_W-1:0] operand, result;
  logic              wr;

  always_comb begin
    operand = ex_from_mem ? mem_rdata : ex_imm;
    result  = ex_load ? operand : acc + operand;
    wr      = ex_valid && (ex_load || ex_add);
    fwd     = wr ? result : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      halted  <= 1'b0;
      retired <= '0;
    end else begin
      if (wr) acc <= result;
      if (ex_valid && !halted) retired <= retired + CNT_W'(1);
      if (ex_valid && ex_halt) halted  <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_pipe_core.sv
module acc_pipe_core #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = DATA_W - acp_pkg::HDR_W,
  parameter int CNT_W       = 16,
  parameter bit SPLIT_PORTS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              a_req,
  output logic              a_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_wdata,
  input  logic [DATA_W-1:0] a_rdata,
  output logic              b_req,
  output logic              b_we,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] b_rdata,
  output logic [DATA_W-1:0] acc_out,
  output logic              halted,
  output logic [CNT_W-1:0]  retired
);
  localparam bit SHARED = !SPLIT_PORTS;

  logic [ADDR_W-1:0] pc;
  logic              fire, dec_valid, port_busy, halt_dec;
  logic              dmem_go, dmem_we;
  logic [ADDR_W-1:0] dmem_addr;
  logic [DATA_W-1:0] dmem_wdata, st_fwd, ex_rdata;
  logic              ex_valid, ex_load, ex_add, ex_halt, ex_from_mem;
  logic [DATA_W-1:0] ex_imm;

  acp_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .port_busy(port_busy), .halt_dec(halt_dec),
    .pc(pc), .fire(fire), .dec_valid(dec_valid)
  );

  acp_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SHARED(SHARED)) u_dec (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .instr(a_rdata), .st_data(st_fwd),
    .dmem_go(dmem_go), .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .port_busy(port_busy), .halt_dec(halt_dec),
    .ex_valid(ex_valid), .ex_load(ex_load), .ex_add(ex_add), .ex_halt(ex_halt),
    .ex_from_mem(ex_from_mem), .ex_imm(ex_imm)
  );

  acp_execute #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_exe (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_load(ex_load), .ex_add(ex_add),
    .ex_halt(ex_halt), .ex_from_mem(ex_from_mem), .ex_imm(ex_imm), .mem_rdata(ex_rdata),
    .acc(acc_out), .halted(halted), .retired(retired), .fwd(st_fwd)
  );

  generate
    if (SHARED) begin : g_shared
      always_comb begin
        a_req    = fire || dmem_go;
        a_we     = dmem_we;
        a_addr   = dmem_go ? dmem_addr : pc;
        a_wdata  = dmem_wdata;
        b_req    = 1'b0;
        b_we     = 1'b0;
        b_addr   = '0;
        b_wdata  = '0;
      end
    end else begin : g_split
      always_comb begin
        a_req    = fire;
        a_we     = 1'b0;
        a_addr   = pc;
        a_wdata  = '0;
        b_req    = dmem_go;
        b_we     = dmem_we;
        b_addr   = dmem_addr;
        b_wdata  = dmem_wdata;
      end
    end
  endgenerate

  assign ex_rdata = SHARED ? a_rdata : b_rdata;
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter bit SPLIT_PORTS = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              a_req,
  input logic              b_req,
  input logic              halted,
  input logic [CNT_W-1:0]  retired,
  input logic [DATA_W-1:0] acc_out,
  input logic              dmem_go,
  input logic              dec_valid
);
  localparam bit SHARED = !SPLIT_PORTS;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R8
  AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc_out)); // R8
  AST_HALT_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(retired)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!a_req && !b_req)); // R8
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (retired != {CNT_W{1'b1}}) |=> ((retired - $past(retired)) <= CNT_W'(1))); // R5
  AST_SHARED_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (SHARED && dmem_go) |=> !dec_valid); // R6
  AST_SPLIT_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (!SHARED && dmem_go) |=> dec_valid); // R7
endmodule

bind acc_pipe_core acp_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .SPLIT_PORTS(SPLIT_PORTS)
) u_chk (
  .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req), .halted(halted),
  .retired(retired), .acc_out(acc_out), .dmem_go(dmem_go), .dec_valid(dec_valid)
);

// File: tb/sim_mem.sv
module sim_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [2**IDX_W];

  always @(posedge clk) begin
    if (a_req) begin
      if (a_we) mem[a_addr[IDX_W-1:0]] <= a_wdata;
      else      a_rdata <= mem[a_addr[IDX_W-1:0]];
    end
    if (b_req) begin
      if (b_we) mem[b_addr[IDX_W-1:0]] <= b_wdata;
      else      b_rdata <= mem[b_addr[IDX_W-1:0]];
    end
    if (ld_en) mem[ld_addr] <= ld_data;
  end
endmodule

// File: tb/sim_acc_pipe_core.sv
module sim_acc_pipe_core;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 8;
  localparam int DEPTH  = 2**IDX_W;
  localparam logic [2:0] LD = 3'b000, AD = 3'b001, ST = 3'b010, HT = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10ns clk = ~clk;

  logic              ld_en = 1'b0;
  logic [IDX_W-1:0]  ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;

  logic              a0_req, a0_we, b0_req, b0_we, halted0;
  logic [ADDR_W-1:0] a0_addr, b0_addr;
  logic [DATA_W-1:0] a0_wdata, a0_rdata, b0_wdata, b0_rdata, acc0;
  logic [CNT_W-1:0]  ret0;
  logic              a1_req, a1_we, b1_req, b1_we, halted1;
  logic [ADDR_W-1:0] a1_addr, b1_addr;
  logic [DATA_W-1:0] a1_wdata, a1_rdata, b1_wdata, b1_rdata, acc1;
  logic [CNT_W-1:0]  ret1;

  acc_pipe_core #(.SPLIT_PORTS(1'b0)) u0 (
    .clk(clk), .rst(rst), .a_req(a0_req), .a_we(a0_we), .a_addr(a0_addr),
    .a_wdata(a0_wdata), .a_rdata(a0_rdata), .b_req(b0_req), .b_we(b0_we),
    .b_addr(b0_addr), .b_wdata(b0_wdata), .b_rdata(b0_rdata),
    .acc_out(acc0), .halted(halted0), .retired(ret0));
  sim_mem u_m0 (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .a_req(a0_req), .a_we(a0_we), .a_addr(a0_addr), .a_wdata(a0_wdata), .a_rdata(a0_rdata),
    .b_req(b0_req), .b_we(b0_we), .b_addr(b0_addr), .b_wdata(b0_wdata), .b_rdata(b0_rdata));

  acc_pipe_core #(.SPLIT_PORTS(1'b1)) u1 (
    .clk(clk), .rst(rst), .a_req(a1_req), .a_we(a1_we), .a_addr(a1_addr),
    .a_wdata(a1_wdata), .a_rdata(a1_rdata), .b_req(b1_req), .b_we(b1_we),
    .b_addr(b1_addr), .b_wdata(b1_wdata), .b_rdata(b1_rdata),
    .acc_out(acc1), .halted(halted1), .retired(ret1));
  sim_mem u_m1 (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .a_req(a1_req), .a_we(a1_we), .a_addr(a1_addr), .a_wdata(a1_wdata), .a_rdata(a1_rdata),
    .b_req(b1_req), .b_we(b1_we), .b_addr(b1_addr), .b_wdata(b1_wdata), .b_rdata(b1_rdata));

  int vecs = 0;
  int fails = 0;
  int edges = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  // reference image and model state
  logic [DATA_W-1:0] img     [DEPTH];
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [DATA_W-1:0] q0[$];
  logic [DATA_W-1:0] q1[$];
  int exp_halt0, exp_halt1, exp_ret;
  logic [DATA_W-1:0] exp_acc;
  string trace_tag = "R2";

  function automatic logic [DATA_W-1:0] enc(input logic [2:0] op, input logic im,
                                            input logic [11:0] v);
    return {op, im, v};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = '0;
  endtask

  // driver: runs the program on a plain sequential model and pushes the
  // expected accumulator after every retirement into both scoreboards
  task automatic predict();
    int pc, f_sh, f_sp, n;
    logic [DATA_W-1:0] acc, w, val;
    logic [2:0] op;
    bit im, mem_op, done;
    pc = 0; f_sh = 1; f_sp = 1; n = 0; acc = '0; done = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = img[i];
    q0.delete(); q1.delete();
    while (!done && n < 200) begin
      w   = ref_mem[pc];
      op  = w[15:13];
      im  = w[12];
      val = im ? {4'h0, w[11:0]} : ref_mem[w[IDX_W-1:0]];
      mem_op = (op == ST) || (((op == LD) || (op == AD)) && !im);
      case (op)
        LD: acc = val;
        AD: acc = acc + val;
        ST: ref_mem[w[IDX_W-1:0]] = acc;
        HT: done = 1;
        default: ;
      endcase
      q0.push_back(acc);
      q1.push_back(acc);
      n++;
      if (done) begin
        exp_halt0 = f_sh + 2;
        exp_halt1 = f_sp + 2;
      end else begin
        f_sh = f_sh + 1 + int'(mem_op);
        f_sp = f_sp + 1;
        pc++;
      end
    end
    exp_ret = n;
    exp_acc = acc;
  endtask

  // monitor state
  logic [CNT_W-1:0]  prev0, prev1, reth0, reth1;
  logic [DATA_W-1:0] acch0, acch1, expv;
  int h0 = -1, h1 = -1;
  bit viol0 = 0, viol1 = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev0 = '0;
      prev1 = '0;
    end else begin
      if (ret0 != prev0) begin
        if (q0.size() == 0) check(1'b0, trace_tag, "u0 extra retirement", ret0, 0);
        else begin
          expv = q0.pop_front();
          check(acc0 == expv, trace_tag, "u0 accumulator at retire", acc0, expv);
        end
        prev0 = ret0;
      end
      if (ret1 != prev1) begin
        if (q1.size() == 0) check(1'b0, trace_tag, "u1 extra retirement", ret1, 0);
        else begin
          expv = q1.pop_front();
          check(acc1 == expv, trace_tag, "u1 accumulator at retire", acc1, expv);
        end
        prev1 = ret1;
      end
      if (halted0 && h0 >= 0 && (a0_req || b0_req || acc0 != acch0 || ret0 != reth0)) viol0 = 1;
      if (halted1 && h1 >= 0 && (a1_req || b1_req || acc1 != acch1 || ret1 != reth1)) viol1 = 1;
      if (halted0 && h0 < 0) begin h0 = edges; acch0 = acc0; reth0 = ret0; end
      if (halted1 && h1 < 0) begin h1 = edges; acch1 = acc1; reth1 = ret1; end
    end
  end

  task automatic load_mems();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = IDX_W'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input string tag0, input string tag1, input string ttag);
    int bad0, bad1;
    predict();
    trace_tag = ttag;
    rst = 1'b1;
    load_mems();
    repeat (2) @(negedge clk);
    check(acc0 == 0 && acc1 == 0, "R1", "accumulator in reset", {acc0, acc1}, 0);
    check(!halted0 && !halted1, "R1", "halted in reset", {halted0, halted1}, 0);
    check(ret0 == 0 && ret1 == 0, "R1", "retired in reset", {ret0, ret1}, 0);
    check(a0_addr == 0 && a1_addr == 0, "R1", "fetch address in reset", {a0_addr, a1_addr}, 0);
    h0 = -1; h1 = -1; viol0 = 0; viol1 = 0;
    rst = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (h0 >= 0 && h1 >= 0) break;
    end
    repeat (6) @(negedge clk);
    check(h0 == exp_halt0, tag0, "u0 halt edge (shared)", h0, exp_halt0);
    check(h1 == exp_halt1, tag1, "u1 halt edge (split)", h1, exp_halt1);
    check(ret0 == exp_ret && ret1 == exp_ret, "R8", "retired total", {ret0, ret1}, exp_ret);
    check(acc0 == exp_acc && acc1 == exp_acc, "R2", "final accumulator", {acc0, acc1}, exp_acc);
    check(q0.size() == 0 && q1.size() == 0, "R8", "pending expected retirements",
          q0.size() + q1.size(), 0);
    check(!viol0 && !viol1, "R8", "activity after halt", {viol0, viol1}, 0);
    bad0 = 0; bad1 = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (u_m0.mem[i] !== ref_mem[i]) bad0++;
      if (u_m1.mem[i] !== ref_mem[i]) bad1++;
    end
    check(bad0 == 0, "R4", "u0 memory words differing", bad0, 0);
    check(bad1 == 0, "R4", "u1 memory words differing", bad1, 0);
  endtask

  initial begin
    // R5 R9: nine immediate instructions, each add depends on the one before
    clear_img();
    img[0] = enc(LD, 1'b1, 12'd1);
    for (int k = 1; k < 8; k++) img[k] = enc(AD, 1'b1, 12'(k + 1));
    img[8] = enc(HT, 1'b0, 12'h000);
    run("R5", "R5", "R9");

    // R3 R4 R6 R7 R10: direct reads, stores, unknown opcodes, halt shadow
    clear_img();
    img[8'h80] = 16'h1234;
    img[8'h81] = 16'h0102;
    img[0]  = enc(LD, 1'b1, 12'h005);
    img[1]  = enc(AD, 1'b0, 12'h080);
    img[2]  = enc(ST, 1'b1, 12'h090);
    img[3]  = enc(LD, 1'b0, 12'h081);
    img[4]  = enc(AD, 1'b1, 12'h00F);
    img[5]  = enc(ST, 1'b0, 12'h091);
    img[6]  = enc(3'b011, 1'b1, 12'h777);
    img[7]  = enc(3'b100, 1'b0, 12'h080);
    img[8]  = enc(LD, 1'b0, 12'h090);
    img[9]  = enc(HT, 1'b0, 12'h000);
    img[10] = enc(LD, 1'b1, 12'hABC);
    run("R6", "R7", "R3");

    // R2: add wraps around, followed by a store of the wrapped sum
    clear_img();
    img[8'h80] = 16'hF001;
    img[0] = enc(LD, 1'b1, 12'hFFF);
    img[1] = enc(AD, 1'b0, 12'h080);
    img[2] = enc(AD, 1'b1, 12'h001);
    img[3] = enc(ST, 1'b0, 12'h082);
    img[4] = enc(HT, 1'b1, 12'h000);
    run("R6", "R7", "R2");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    vecs++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule